// File: doc/BRIEF.md
# Indirection-table video fetch controller

This block is a display engine that owns a byte-wide shared SRAM as bus master. It makes its own raster timing and, for every group of four displayed scan lines, reads one two-byte entry from a line table in memory. That entry names a 256-byte page and a starting column. The engine then reads the visible pixel bytes of the line from that page, with the column wrapping inside the page. Software can scroll single lines sideways, or show one source line in several places, by editing only the table.

Each fetched line goes into one half of an on-chip ping-pong buffer and is shown for four scan lines in a row. The next line is fetched into the other half while the current one is on screen, and the first line of a frame is fetched during vertical blanking. A compatibility input makes the engine raise a CPU-halt output for as long as it is fetching. Line and frame start strobes let neighbouring I/O logic align to the raster.

Top module: `vidfetch_ctrl`

## Requirements
- R1: While `rst_n` is low, `de`, `hsync`, `vsync`, `line_stb`, `frame_stb`, `mem_req`, `cpu_halt` and all colour outputs are 0.
- R2: A scan line lasts H_ACTIVE+H_FP+H_SYNC+H_BP cycles and a frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines, where V_ACTIVE = 4*LINES. `de` is high for H_ACTIVE cycles on each of the first V_ACTIVE lines. `hsync` is high for H_SYNC cycles per line and `vsync` is high for V_SYNC whole lines per frame. Neither sync is high while `de` is high.
- R3: The table entry for quad line q is read as two bytes in this order: the page at TBL_BASE+2q, then the start column at TBL_BASE+2q+1. Quad line 1 is fetched first after reset, starting on the first cycle after reset is released.
- R4: Pixel x (0-based) of quad line q is the byte at address {page, (column + x) mod 256}.
- R5: Scan lines 4q to 4q+3 all show the pixels of quad line q.
- R6: Each frame accepts exactly LINES*(2+H_ACTIVE) memory reads, which means each quad line is fetched once.
- R7: Colour comes from the low six bits of a pixel byte: red is bits 5:4, green is bits 3:2 and blue is bits 1:0. All colour outputs are 0 whenever `de` is low.
- R8: A request held while `mem_gnt` is low keeps `mem_req` high and `mem_addr` unchanged. Read data is taken from `mem_rdata` one cycle after a request is accepted. The picture stays correct with any grant pattern that completes a fetch within four scan lines.
- R9: With `compat_halt_en` high, `cpu_halt` is high in every cycle in which `mem_req` is high. With `compat_halt_en` low, `cpu_halt` stays 0.
- R10: `line_stb` pulses for one cycle at the start of every scan line, in the same cycle as the first pixel of active lines. `frame_stb` pulses together with the `line_stb` of scan line 0, including the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| compat_halt_en | input | 1 | Raise `cpu_halt` while fetching |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_gnt | input | 1 | Request accepted in this cycle |
| mem_rdata | input | 8 | Read data, one cycle after acceptance |
| cpu_halt | output | 1 | Halt request to the processor |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active picture region |
| red | output | 2 | Red level |
| green | output | 2 | Green level |
| blue | output | 2 | Blue level |
| line_stb | output | 1 | Start of scan line |
| frame_stb | output | 1 | Start of frame |

## Verification
A corrupt page, column or buffer half appears as wrong colour on the very next active line that reads it. That can be the same frame or, for quad line 0, the frame after the corrupt fetch. A fetch that loses a byte or issues an extra request changes the per-frame request count and the table address order at the next frame strobe. A timing counter that slips shows up within one line as a moved sync or strobe, and within one frame in the cycle, sync and `de` counts. The bench compares every pixel and every blanked cycle under three grant patterns, both with and without halt mode, and across a reset in mid-frame.

// File: rtl/vf_pkg.sv
package vf_pkg;

    typedef enum logic [2:0] {
        F_IDLE,
        F_TPAGE,
        F_TCOL,
        F_TWAIT,
        F_PIX
    } fetch_st_e;

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
        logic lstb;
        logic fstb;
    } vid_ctl_t;

endpackage

// File: rtl/vf_timing.sv
module vf_timing #(
    parameter int H_ACTIVE = 160,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 24,
    parameter int H_BP     = 40,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    localparam int HT = H_ACTIVE + H_FP + H_SYNC + H_BP,
    localparam int VT = V_ACTIVE + V_FP + V_SYNC + V_BP,
    localparam int HW = $clog2(HT),
    localparam int VW = $clog2(VT)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output logic          active,
    output logic          hsync,
    output logic          vsync
);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } tim_t;

    tim_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (int'(t_q.h) == HT - 1) begin
            t_d.h = '0;
            t_d.v = (int'(t_q.v) == VT - 1) ? '0 : t_q.v + 1'b1;
        end else begin
            t_d.h = t_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign h_cnt  = t_q.h;
    assign v_cnt  = t_q.v;
    assign active = (int'(t_q.h) < H_ACTIVE) && (int'(t_q.v) < V_ACTIVE);
    assign hsync  = (int'(t_q.h) >= H_ACTIVE + H_FP) &&
                    (int'(t_q.h) <  H_ACTIVE + H_FP + H_SYNC);
    assign vsync  = (int'(t_q.v) >= V_ACTIVE + V_FP) &&
                    (int'(t_q.v) <  V_ACTIVE + V_FP + V_SYNC);

endmodule

// File: rtl/vf_fetch.sv
module vf_fetch
    import vf_pkg::*;
#(
    parameter int          H_ACTIVE = 160,
    parameter int          LINES    = 120,
    parameter int          COLW     = 6,
    parameter logic [15:0] TBL_BASE = 16'h0000,
    localparam int QW = $clog2(LINES),
    localparam int CW = $clog2(H_ACTIVE + 1),
    localparam int BW = $clog2(2 * H_ACTIVE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kick,
    input  logic [QW-1:0]   kick_quad,
    output logic            mem_req,
    output logic [15:0]     mem_addr,
    input  logic            mem_gnt,
    input  logic [7:0]      mem_rdata,
    output logic            busy,
    output logic            wr_en,
    output logic [BW-1:0]   wr_addr,
    output logic [COLW-1:0] wr_data
);

    typedef struct packed {
        fetch_st_e     st;
        logic [QW-1:0] quad;
        logic [7:0]    page;
        logic [7:0]    col;
        logic [CW-1:0] issue;
        logic [CW-1:0] widx;
        logic          rv;
    } fetch_t;

    fetch_t f_d, f_q;
    logic [15:0] tbl_addr;

    assign tbl_addr = TBL_BASE + 16'({f_q.quad, 1'b0});

    always_comb begin
        f_d      = f_q;
        mem_req  = 1'b0;
        mem_addr = '0;
        wr_en    = 1'b0;
        case (f_q.st)
            F_IDLE: begin
                if (kick) begin
                    f_d.st    = F_TPAGE;
                    f_d.quad  = kick_quad;
                    f_d.issue = '0;
                    f_d.widx  = '0;
                end
            end
            F_TPAGE: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
                if (mem_gnt) f_d.st = F_TCOL;
            end
            F_TCOL: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr + 16'd1;
                if (f_q.rv)  f_d.page = mem_rdata;
                if (mem_gnt) f_d.st = F_TWAIT;
            end
            F_TWAIT: begin
                f_d.col = mem_rdata;
                f_d.st  = F_PIX;
            end
            F_PIX: begin
                if (int'(f_q.issue) < H_ACTIVE) begin
                    mem_req  = 1'b1;
                    mem_addr = {f_q.page, f_q.col + 8'(f_q.issue)};
                    if (mem_gnt) f_d.issue = f_q.issue + 1'b1;
                end
                if (f_q.rv) begin
                    wr_en    = 1'b1;
                    f_d.widx = f_q.widx + 1'b1;
                    if (int'(f_q.widx) == H_ACTIVE - 1) f_d.st = F_IDLE;
                end
            end
            default: f_d.st = F_IDLE;
        endcase
        f_d.rv = mem_req & mem_gnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q    <= '0;
            f_q.st <= F_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign busy    = (f_q.st != F_IDLE);
    assign wr_addr = f_q.quad[0] ? BW'(H_ACTIVE) + BW'(f_q.widx) : BW'(f_q.widx);
    assign wr_data = mem_rdata[COLW-1:0];

    AST_KICK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> !busy);  // R6
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));  // R8

endmodule

// File: rtl/vf_linebuf.sv
module vf_linebuf #(
    parameter int DEPTH = 320,
    parameter int DW    = 6,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
        rd_q <= mem_q[rd_addr];
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/vidfetch_ctrl.sv
module vidfetch_ctrl
    import vf_pkg::*;
#(
    parameter int          H_ACTIVE = 160,
    parameter int          H_FP     = 16,
    parameter int          H_SYNC   = 24,
    parameter int          H_BP     = 40,
    parameter int          LINES    = 120,
    parameter int          V_FP     = 10,
    parameter int          V_SYNC   = 2,
    parameter int          V_BP     = 33,
    parameter logic [15:0] TBL_BASE = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        compat_halt_en,
    output logic        mem_req,
    output logic [15:0] mem_addr,
    input  logic        mem_gnt,
    input  logic [7:0]  mem_rdata,
    output logic        cpu_halt,
    output logic        hsync,
    output logic        vsync,
    output logic        de,
    output logic [1:0]  red,
    output logic [1:0]  green,
    output logic [1:0]  blue,
    output logic        line_stb,
    output logic        frame_stb
);

    localparam int V_ACTIVE = 4 * LINES;
    localparam int HT   = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int VT   = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HW   = $clog2(HT);
    localparam int VW   = $clog2(VT);
    localparam int QW   = $clog2(LINES);
    localparam int BW   = $clog2(2 * H_ACTIVE);
    localparam int COLW = 6;

    logic [HW-1:0]   h_cnt;
    logic [VW-1:0]   v_cnt;
    logic            act, hs, vs;
    logic            kick, busy, wr_en;
    logic [QW-1:0]   kick_quad;
    logic [BW-1:0]   wr_addr, rd_addr;
    logic [COLW-1:0] wr_data, rd_data;
    vid_ctl_t        ctl_d, ctl_q;

    vf_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
    ) u_tim (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
        .active(act), .hsync(hs), .vsync(vs)
    );

    vf_fetch #(
        .H_ACTIVE(H_ACTIVE), .LINES(LINES), .COLW(COLW), .TBL_BASE(TBL_BASE)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .kick(kick), .kick_quad(kick_quad),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .busy(busy), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    vf_linebuf #(
        .DEPTH(2 * H_ACTIVE), .DW(COLW)
    ) u_buf (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Fetch scheduling: quad 0 at the start of vertical blanking,
    // quad q+1 at the first scan line of quad q.
    always_comb begin
        kick      = 1'b0;
        kick_quad = '0;
        if (h_cnt == '0) begin
            if (int'(v_cnt) == V_ACTIVE) begin
                kick = 1'b1;
            end else if ((int'(v_cnt) < V_ACTIVE) && (v_cnt[1:0] == 2'b00) &&
                         ((int'(v_cnt) >> 2) < LINES - 1)) begin
                kick      = 1'b1;
                kick_quad = QW'(v_cnt >> 2) + 1'b1;
            end
        end
    end

    always_comb begin
        rd_addr = '0;
        if (act) rd_addr = v_cnt[2] ? BW'(H_ACTIVE) + BW'(h_cnt) : BW'(h_cnt);
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.de   = act;
        ctl_d.hs   = hs;
        ctl_d.vs   = vs;
        ctl_d.lstb = (h_cnt == '0);
        ctl_d.fstb = (h_cnt == '0) && (v_cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign de        = ctl_q.de;
    assign hsync     = ctl_q.hs;
    assign vsync     = ctl_q.vs;
    assign line_stb  = ctl_q.lstb;
    assign frame_stb = ctl_q.fstb;
    assign red       = ctl_q.de ? rd_data[5:4] : 2'b00;
    assign green     = ctl_q.de ? rd_data[3:2] : 2'b00;
    assign blue      = ctl_q.de ? rd_data[1:0] : 2'b00;
    assign cpu_halt  = compat_halt_en & busy;

    AST_SYNC_OUTSIDE_PICTURE: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hsync && !vsync));  // R2
    AST_HALT_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (compat_halt_en && mem_req) |-> cpu_halt);  // R9
    AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> line_stb);  // R10

endmodule

// File: tb/vidfetch_ctrl_bench.sv
`timescale 1ns/1ps
module vidfetch_ctrl_bench;

    localparam int HA = 8, HFP = 2, HSY = 4, HBP = 6;
    localparam int LN = 4, VFP = 1, VSY = 2, VBP = 1;
    localparam int VA = 4 * LN;
    localparam int HT = HA + HFP + HSY + HBP;
    localparam int VT = VA + VFP + VSY + VBP;
    localparam int FRAME = HT * VT;

    // line table: {page, start column}; entry 1 wraps, entry 2 reuses entry 0
    localparam logic [15:0] LINE_TBL [LN] = '{16'h1200, 16'h34FC, 16'h1200, 16'h5680};
    // scenario vectors: {halt mode, grant pattern}
    localparam logic [2:0] SCEN [6] = '{3'b000, 3'b100, 3'b001, 3'b101, 3'b010, 3'b110};

    logic clk = 1'b0, rst_n = 1'b0, compat_halt_en = 1'b0;
    logic mem_req, mem_gnt = 1'b0, cpu_halt, hsync, vsync, de, line_stb, frame_stb;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'hA5;
    logic [1:0]  red, green, blue;

    int n_tests = 0, n_fail = 0, cyc = 0;
    int stall_mode = 0;

    always #2 clk = ~clk;

    vidfetch_ctrl #(
        .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
        .LINES(LN), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP), .TBL_BASE(16'h0000)
    ) u_vidfetch_ctrl (
        .clk(clk), .rst_n(rst_n), .compat_halt_en(compat_halt_en),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .cpu_halt(cpu_halt), .hsync(hsync), .vsync(vsync),
        .de(de), .red(red), .green(green), .blue(blue),
        .line_stb(line_stb), .frame_stb(frame_stb)
    );

    function automatic logic [7:0] sram_rd(input logic [15:0] a);
        if (int'(a) < 2 * LN) begin
            return a[0] ? LINE_TBL[int'(a) >> 1][7:0] : LINE_TBL[int'(a) >> 1][15:8];
        end
        return a[7:0] ^ a[15:8];
    endfunction

    always @(posedge clk) begin
        if (mem_req && mem_gnt) mem_rdata <= sram_rd(mem_addr);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // monitor state
    int y = 0, x = 0, frames = 0, frame_cyc = 0, de_c = 0, hs_c = 0, vs_c = 0, acc_c = 0;
    int exp_tbl = 2;
    logic prev_stall = 1'b0;
    logic [15:0] prev_addr = '0;

    always @(negedge clk) begin
        cyc++;
        case (stall_mode)
            1:       mem_gnt = (cyc % 3) != 0;
            2:       mem_gnt = (cyc % 4) >= 2;
            default: mem_gnt = 1'b1;
        endcase
        #1;
        if (!rst_n) begin
            y = 0; x = 0; frames = 0; frame_cyc = 0; de_c = 0; hs_c = 0;
            vs_c = 0; acc_c = 0; exp_tbl = 2; prev_stall = 1'b0;
        end else begin
            if (frame_stb) begin
                frames++;
                if (frames >= 2) begin
                    chk(frame_cyc == FRAME, "R2 frame length", frame_cyc, FRAME);
                    chk(de_c == HA * VA, "R2 de cycles", de_c, HA * VA);
                    chk(hs_c == HSY * VT, "R2 hsync cycles", hs_c, HSY * VT);
                    chk(vs_c == VSY * HT, "R2 vsync cycles", vs_c, VSY * HT);
                    chk(acc_c == LN * (2 + HA), "R6 reads per frame", acc_c, LN * (2 + HA));
                end
                frame_cyc = 0; de_c = 0; hs_c = 0; vs_c = 0; acc_c = 0;
            end
            if (line_stb) begin
                y = frame_stb ? 0 : y + 1;
                x = 0;
                if (y < VA) chk(de == 1'b1, "R10 line_stb on first pixel", de, 1);
            end
            if (de) begin
                if (y >= VA) chk(1'b0, "R2 de outside active lines", y, VA - 1);
                else if (frames >= 2) begin
                    logic [7:0] pg, col, pix;
                    pg  = LINE_TBL[y / 4][15:8];
                    col = LINE_TBL[y / 4][7:0];
                    pix = sram_rd({pg, col + 8'(x)});
                    if (y % 4 == 0)
                        chk({red, green, blue} == pix[5:0], "R4 R7 pixel", {red, green, blue}, pix[5:0]);
                    else
                        chk({red, green, blue} == pix[5:0], "R5 replayed pixel", {red, green, blue}, pix[5:0]);
                end
                x++;
            end else begin
                chk({red, green, blue} == 6'd0, "R7 blanked colour", {red, green, blue}, 0);
            end
            if (compat_halt_en) begin
                if (mem_req) chk(cpu_halt == 1'b1, "R9 halt during fetch", cpu_halt, 1);
            end else begin
                chk(cpu_halt == 1'b0, "R9 halt off", cpu_halt, 0);
            end
            if (prev_stall)
                chk(mem_req && mem_addr == prev_addr, "R8 request held", mem_addr, prev_addr);
            if (mem_req && mem_gnt) begin
                acc_c++;
                if (int'(mem_addr) < 2 * LN) begin
                    chk(int'(mem_addr) == exp_tbl, "R3 table order", mem_addr, exp_tbl);
                    exp_tbl = (exp_tbl + 1) % (2 * LN);
                end
            end
            prev_stall = mem_req && !mem_gnt;
            prev_addr  = mem_addr;
            de_c += int'(de); hs_c += int'(hsync); vs_c += int'(vsync);
            frame_cyc++;
        end
    end

    always @(posedge clk) begin
        if (cyc > 60000) begin
            chk(1'b0, "watchdog", cyc, 60000);
            finish_run();
        end
    end

    task automatic check_reset_outputs();
        chk({de, hsync, vsync, line_stb, frame_stb} == 5'd0, "R1 ctl in reset",
            {de, hsync, vsync, line_stb, frame_stb}, 0);
        chk({red, green, blue} == 6'd0, "R1 colour in reset", {red, green, blue}, 0);
        chk(mem_req == 1'b0 && cpu_halt == 1'b0, "R1 req/halt in reset", {mem_req, cpu_halt}, 0);
    endtask

    initial begin
        compat_halt_en = 1'b1;
        repeat (3) @(negedge clk);
        #1 check_reset_outputs();
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(frame_stb && line_stb, "R10 frame strobe after reset", {frame_stb, line_stb}, 3);
        chk(mem_req && mem_addr == 16'd2, "R3 first table read", mem_addr, 2);

        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            compat_halt_en = SCEN[i][2];
            stall_mode     = int'(SCEN[i][1:0]);
            repeat (2 * FRAME) @(negedge clk);
        end

        // reset in mid-frame, then run again with sparse grants
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        compat_halt_en = 1'b1;
        repeat (2) @(negedge clk);
        #1 check_reset_outputs();
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        #1 chk(frame_stb == 1'b1, "R10 frame strobe after second reset", frame_stb, 1);
        stall_mode = 2;
        repeat (3 * FRAME) @(negedge clk);
        finish_run();
    end

endmodule